// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block sits on the device side of an asynchronous DRAM interface with two byte lanes. It samples the active-low row strobe, the two lane column strobes, write enable and output enable on a system clock. For every memory cycle it reports what kind of cycle the controller is running: idle, row-only refresh, read, early write, late write or read-modify-write, CAS-before-RAS refresh, hidden refresh, or the read-data hold that comes before a hidden refresh. It also merges the two column strobes into one internal column strobe and produces per-lane output-drive and write-strobe enables.

The row address to use is held on an output. A normal cycle captures the external address when the row strobe falls. A refresh started with a column strobe already low takes its row from an internal refresh counter and ignores the address pins. The counter advances once at the end of each such refresh and wraps. All outputs are registered. Each reflects the strobes sampled at the same clock edge that updates it.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While `rst` is high and at the first edge after it, `cyc_type` is 0, `cas_int`, `oe_lane` and `we_lane` are 0 and `row_addr` is 0.
- R2: `cas_int` is high whenever at least one lane strobe was sampled low. It rises with the first lane to fall and drops only after the last lane returns high.
- R3: Cycle codes are: 0 idle, 1 row-only refresh, 2 read, 3 early write, 4 late write or read-modify-write, 5 CAS-before-RAS refresh, 6 hidden refresh, 7 read-data hold. When the row strobe falls with both column strobes high, the code becomes 1. When it falls with any column strobe low, the code becomes 5, or 6 if the code was 7.
- R4: With the row strobe held low, each falling of the merged column strobe starts an access. With write enable low the code is 3, otherwise 2. In code 2, write enable low while a column strobe is low changes the code to 4.
- R5: When the row strobe falls with both column strobes high, `row_addr` takes `addr`. When any column strobe is low at that moment, `row_addr` takes the refresh counter and `addr` has no effect. `row_addr` does not change while the row strobe stays low.
- R6: The refresh counter starts at 0 and advances by one each time the row strobe rises after code 5 or 6. It wraps from 1023 to 0.
- R7: When the row strobe rises while a column strobe stays low after code 2, 6 or 7, the code becomes 7. Output drive continues for each lane whose strobe is low while output enable is low.
- R8: `oe_lane` bit 0 belongs to the lower lane and bit 1 to the upper lane. A bit is high only when that lane's strobe is low, output enable is low, and the code is 2 with the row strobe low, or the code is 6 or 7.
- R9: `we_lane` uses the same bit order. A bit is high only when the row strobe, that lane's strobe and write enable are all low and the code is 3 or 4. Refresh cycles never raise it.
- R10: With the row strobe high and both column strobes high, the code is 0 and every lane enable is 0.
- R11: Between column strobe pulses in one row cycle the code holds its value. The next falling column strobe classifies again, so reads and writes can be mixed in one page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Lower-lane column strobe, active low |
| cas_hi_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed address pins |
| cyc_type | output | 3 | Cycle code (see R3) |
| cas_int | output | 1 | Merged internal column strobe, active high |
| oe_lane | output | 2 | Per-lane output drive enable |
| we_lane | output | 2 | Per-lane write strobe |
| row_addr | output | 10 | Row to activate or refresh |

## Verification
On every cycle, the assertions check that lane enables never appear without the merged column strobe, and that idle and CAS-before-RAS refresh cycles drive no lane. They also check that the row address is frozen while the row strobe is held low, that the refresh counter only ever steps by one, and that a hidden refresh is only entered from a read-data hold. Only the bench scenarios can show the choices that depend on ordering. These are early versus late writes, byte-lane selection in page mode, the address being ignored during counter-driven refresh, and the counter wrapping after 1024 refreshes.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_ROWREF   = 3'd1,
    CYC_RD       = 3'd2,
    CYC_WR_EARLY = 3'd3,
    CYC_WR_LATE  = 3'd4,
    CYC_CBR      = 3'd5,
    CYC_HIDDEN   = 3'd6,
    CYC_HOLD     = 3'd7
  } cyc_e;
endpackage

// File: rtl/dsd_strobe_sampler.sv
module dsd_strobe_sampler #(
  parameter int NL = dsd_pkg::LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic [NL-1:0] cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  output logic          ras_act,
  output logic          ras_fall,
  output logic          ras_rise,
  output logic [NL-1:0] cas_act,
  output logic          cas_any,
  output logic          cas_fall,
  output logic          we_act,
  output logic          oe_act,
  output logic          ras_prev
);
  logic cas_prev;

  always_comb begin
    ras_act  = ~ras_n;
    cas_act  = ~cas_n;
    cas_any  = |cas_act;
    we_act   = ~we_n;
    oe_act   = ~oe_n;
    ras_fall = ras_act & ~ras_prev;
    ras_rise = ~ras_act & ras_prev;
    cas_fall = cas_any & ~cas_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_prev <= 1'b0;
      cas_prev <= 1'b0;
    end else begin
      ras_prev <= ras_act;
      cas_prev <= cas_any;
    end
  end
endmodule

// File: rtl/dsd_cycle_fsm.sv
module dsd_cycle_fsm
  import dsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ras_act,
  input  logic ras_fall,
  input  logic cas_any,
  input  logic cas_fall,
  input  logic we_act,
  output cyc_e mode_q,
  output cyc_e mode_d
);
  logic keeps_data;
  logic is_access;

  always_comb begin
    keeps_data = (mode_q == CYC_RD) || (mode_q == CYC_HIDDEN) || (mode_q == CYC_HOLD);
    is_access  = (mode_q == CYC_ROWREF) || (mode_q == CYC_RD) ||
                 (mode_q == CYC_WR_EARLY) || (mode_q == CYC_WR_LATE);
    mode_d = mode_q;
    if (!ras_act) begin
      mode_d = (cas_any && keeps_data) ? CYC_HOLD : CYC_IDLE;
    end else if (ras_fall) begin
      if (cas_any) mode_d = (mode_q == CYC_HOLD) ? CYC_HIDDEN : CYC_CBR;
      else         mode_d = CYC_ROWREF;
    end else if (is_access) begin
      if (cas_fall)                                   mode_d = we_act ? CYC_WR_EARLY : CYC_RD;
      else if (mode_q == CYC_RD && cas_any && we_act) mode_d = CYC_WR_LATE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= CYC_IDLE;
    else     mode_q <= mode_d;
  end

  assert_hidden_after_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CYC_HIDDEN && $past(mode_q) != CYC_HIDDEN) |-> $past(mode_q) == CYC_HOLD);
endmodule

// File: rtl/dsd_refresh_row.sv
module dsd_refresh_row
  import dsd_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_any,
  input  cyc_e             mode_q,
  input  logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] row_q
);
  localparam logic [ROW_W-1:0] STEP = ROW_W'(1);

  logic [ROW_W-1:0] cnt_q;
  logic             bump;

  assign bump = ras_rise && (mode_q == CYC_CBR || mode_q == CYC_HIDDEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      if (bump)     cnt_q <= cnt_q + STEP;
      if (ras_fall) row_q <= cas_any ? cnt_q : addr;
    end
  end

  assert_ctr_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + STEP));
endmodule

// File: rtl/dsd_lane_gate.sv
module dsd_lane_gate
  import dsd_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_act,
  input  logic [NL-1:0] cas_act,
  input  logic          cas_any,
  input  logic          we_act,
  input  logic          oe_act,
  input  cyc_e          mode_d,
  output logic [NL-1:0] oe_q,
  output logic [NL-1:0] we_q,
  output logic          cas_q
);
  logic          rd_ok;
  logic          wr_ok;
  logic [NL-1:0] oe_d;
  logic [NL-1:0] we_d;

  assign rd_ok = (mode_d == CYC_RD && ras_act) || mode_d == CYC_HIDDEN || mode_d == CYC_HOLD;
  assign wr_ok = (mode_d == CYC_WR_EARLY || mode_d == CYC_WR_LATE) && ras_act;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign oe_d[i] = cas_act[i] & oe_act & rd_ok;
    assign we_d[i] = cas_act[i] & we_act & wr_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      we_q  <= '0;
      cas_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      we_q  <= we_d;
      cas_q <= cas_any;
    end
  end

  assert_lane_drive_or_write_R8: assert property (@(posedge clk) disable iff (rst)
    (oe_q & we_q) == '0);
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_lo_n,
  input  logic             cas_hi_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic [2:0]       cyc_type,
  output logic             cas_int,
  output logic [LANES-1:0] oe_lane,
  output logic [LANES-1:0] we_lane,
  output logic [ROW_W-1:0] row_addr
);
  logic             ras_act, ras_fall, ras_rise, ras_prev;
  logic [LANES-1:0] cas_act;
  logic             cas_any, cas_fall, we_act, oe_act;
  cyc_e             mode_q, mode_d;

  dsd_strobe_sampler #(.NL(LANES)) u_samp (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n({cas_hi_n, cas_lo_n}),
    .we_n(we_n), .oe_n(oe_n), .ras_act(ras_act), .ras_fall(ras_fall),
    .ras_rise(ras_rise), .cas_act(cas_act), .cas_any(cas_any),
    .cas_fall(cas_fall), .we_act(we_act), .oe_act(oe_act), .ras_prev(ras_prev)
  );

  dsd_cycle_fsm u_fsm (
    .clk(clk), .rst(rst), .ras_act(ras_act), .ras_fall(ras_fall),
    .cas_any(cas_any), .cas_fall(cas_fall), .we_act(we_act),
    .mode_q(mode_q), .mode_d(mode_d)
  );

  dsd_refresh_row #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_any(cas_any), .mode_q(mode_q), .addr(addr), .row_q(row_addr)
  );

  dsd_lane_gate #(.NL(LANES)) u_lane (
    .clk(clk), .rst(rst), .ras_act(ras_act), .cas_act(cas_act),
    .cas_any(cas_any), .we_act(we_act), .oe_act(oe_act), .mode_d(mode_d),
    .oe_q(oe_lane), .we_q(we_lane), .cas_q(cas_int)
  );

  assign cyc_type = mode_q;

  assert_lane_needs_cas_R2: assert property (@(posedge clk) disable iff (rst)
    (|{oe_lane, we_lane}) |-> cas_int);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == CYC_IDLE) |-> (oe_lane == '0 && we_lane == '0));

  assert_refresh_no_io_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == CYC_CBR) |-> (oe_lane == '0 && we_lane == '0));

  assert_row_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (ras_prev && $past(ras_prev)) |-> $stable(row_addr));
endmodule

// File: tb/dram_strobe_decoder_test.sv
module dram_strobe_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [2:0] cyc_type;
  logic       cas_int;
  logic [1:0] oe_lane, we_lane;
  logic [9:0] row_addr;

  int checks = 0;
  int errors = 0;
  int refreshes = 0;
  bit done = 0;

  int m_mode = 0, m_cnt = 0, m_row = 0;
  bit m_rp = 0, m_cp = 0, e_cas = 0;
  logic [1:0] e_oe = 0, e_we = 0;

  always #2 clk = ~clk;

  dram_strobe_decoder uut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type), .cas_int(cas_int),
    .oe_lane(oe_lane), .we_lane(we_lane), .row_addr(row_addr)
  );

  // behavioural reference, updated on each sampling edge
  always @(posedge clk) begin
    bit r, lo, hi, ca, rf, rr, cf, rd, wr;
    int nm;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_row = 0; m_rp = 0; m_cp = 0;
      e_cas = 0; e_oe = 0; e_we = 0;
    end else begin
      r = !ras_n; lo = !cas_lo_n; hi = !cas_hi_n; ca = lo || hi;
      rf = r && !m_rp; rr = !r && m_rp; cf = ca && !m_cp;
      nm = m_mode;
      if (!r) nm = (ca && (m_mode == 2 || m_mode == 6 || m_mode == 7)) ? 7 : 0;
      else if (rf) nm = ca ? ((m_mode == 7) ? 6 : 5) : 1;
      else if (m_mode >= 1 && m_mode <= 4) begin
        if (cf) nm = !we_n ? 3 : 2;
        else if (m_mode == 2 && ca && !we_n) nm = 4;
      end
      if (rf) m_row = ca ? m_cnt : int'(addr);
      if (rr && (m_mode == 5 || m_mode == 6)) m_cnt = (m_cnt + 1) % 1024;
      rd = (nm == 2 && r) || nm == 6 || nm == 7;
      wr = (nm == 3 || nm == 4) && r;
      e_oe = {hi && !oe_n && rd, lo && !oe_n && rd};
      e_we = {hi && !we_n && wr, lo && !we_n && wr};
      e_cas = ca;
      m_mode = nm; m_rp = r; m_cp = ca;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 R4 R7 R11 cyc_type", int'(cyc_type), m_mode);
      check("R2 cas_int", int'(cas_int), int'(e_cas));
      check("R8 oe_lane", int'(oe_lane), int'(e_oe));
      check("R9 we_lane", int'(we_lane), int'(e_we));
      check("R5 row_addr", int'(row_addr), m_row);
    end
  end

  task automatic put(input logic r, input logic lo, input logic hi,
                     input logic w, input logic o, input logic [9:0] a);
    @(negedge clk);
    ras_n = r; cas_lo_n = lo; cas_hi_n = hi; we_n = w; oe_n = o; addr = a;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic cbr_cycle(input logic [9:0] junk);
    put(1, 0, 0, 1, 1, junk);
    put(0, 0, 0, 0, 1, junk);
    settle();
    check("R5 R6 refresh row from counter", int'(row_addr), refreshes % 1024);
    check("R3 code 5", int'(cyc_type), 5);
    put(1, 0, 0, 1, 1, junk);
    refreshes++;
    put(1, 1, 1, 1, 1, junk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(cyc_type), 0);
    check("R1 reset lanes", int'({oe_lane, we_lane, cas_int}), 0);
    check("R1 reset row", int'(row_addr), 0);
    rst = 1'b0;
    settle();
    check("R1 after reset", int'(cyc_type), 0);
    check("R10 idle", int'({oe_lane, we_lane}), 0);

    // row-only refresh
    put(0, 1, 1, 1, 1, 10'h155);
    settle();
    check("R3 row-only code", int'(cyc_type), 1);
    check("R5 latched row", int'(row_addr), 10'h155);
    put(0, 1, 1, 1, 1, 10'h0AA);
    settle();
    check("R5 row frozen", int'(row_addr), 10'h155);
    put(1, 1, 1, 1, 1, 0);

    // word read, then page-mode byte reads and a write in the same row
    put(0, 1, 1, 1, 0, 10'h2AA);
    put(0, 0, 0, 1, 0, 10'h011);
    settle();
    check("R4 read code", int'(cyc_type), 2);
    check("R8 word read lanes", int'(oe_lane), 3);
    put(0, 1, 1, 1, 0, 0);
    settle();
    check("R11 code held between pulses", int'(cyc_type), 2);
    check("R8 no drive with strobes high", int'(oe_lane), 0);
    put(0, 0, 1, 1, 0, 10'h012);
    settle();
    check("R8 lower byte only", int'(oe_lane), 1);
    put(0, 1, 1, 1, 0, 0);
    put(0, 1, 0, 1, 0, 10'h013);
    settle();
    check("R8 upper byte only", int'(oe_lane), 2);
    put(0, 1, 1, 0, 1, 0);
    put(0, 1, 0, 0, 1, 10'h014);
    settle();
    check("R11 page write after read", int'(cyc_type), 3);
    check("R9 upper write", int'(we_lane), 2);
    put(1, 1, 1, 1, 1, 0);
    settle();
    check("R10 back to idle", int'(cyc_type), 0);

    // early write, lower byte
    put(0, 1, 1, 0, 0, 10'h300);
    put(0, 0, 1, 0, 0, 10'h001);
    settle();
    check("R4 early write", int'(cyc_type), 3);
    check("R9 lower write", int'(we_lane), 1);
    check("R8 no drive on write", int'(oe_lane), 0);
    put(1, 1, 1, 1, 1, 0);

    // late write: read, then WE falls with OE high
    put(0, 1, 1, 1, 1, 10'h301);
    put(0, 0, 0, 1, 0, 10'h002);
    put(0, 0, 0, 1, 1, 10'h002);
    put(0, 0, 0, 0, 1, 10'h002);
    settle();
    check("R4 late write", int'(cyc_type), 4);
    check("R9 late write lanes", int'(we_lane), 3);
    put(1, 1, 1, 1, 1, 0);

    // staggered strobes: merged strobe spans first fall to last rise
    put(0, 1, 1, 1, 1, 10'h050);
    put(0, 0, 1, 1, 1, 0);
    put(0, 0, 0, 1, 1, 0);
    put(0, 1, 0, 1, 1, 0);
    settle();
    check("R2 merged strobe held by upper lane", int'(cas_int), 1);
    put(0, 1, 1, 1, 1, 0);
    settle();
    check("R2 merged strobe released", int'(cas_int), 0);
    put(1, 1, 1, 1, 1, 0);

    // refresh with the address pins toggling
    cbr_cycle(10'h3FF);
    cbr_cycle(10'h155);

    // hidden refresh after a read
    put(0, 1, 1, 1, 0, 10'h123);
    put(0, 0, 0, 1, 0, 10'h004);
    put(1, 0, 0, 1, 0, 10'h3FF);
    settle();
    check("R7 hold code", int'(cyc_type), 7);
    check("R7 data kept driven", int'(oe_lane), 3);
    put(0, 0, 0, 1, 0, 10'h3FF);
    settle();
    check("R3 R7 hidden refresh", int'(cyc_type), 6);
    check("R5 hidden uses counter", int'(row_addr), refreshes % 1024);
    put(1, 0, 0, 1, 0, 0);
    refreshes++;
    put(1, 1, 1, 1, 1, 0);
    settle();
    check("R10 idle after hidden", int'({cyc_type, oe_lane}), 0);

    // run the counter through its wrap
    for (int i = 0; i < 1030; i++) cbr_cycle(10'(i * 7));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule